// File: doc/BRIEF.md
# Dual-Issue Pairing Dispatcher

This block sits after decode in a two-wide in-order machine. Each cycle it sees an older and a younger instruction, each with a valid flag and a 4-bit class code. It decides whether both go out together, only the older one goes out, or nothing goes out. It then names the pipe that each issued instruction goes to.

The machine has two execution pipes. The memory pipe holds one adder/address-generation unit. The second pipe holds an adder, a branch unit, an integer multiply/divide unit and three floating-point units, and only one of these can be claimed per cycle. The older slot may pair only with certain classes, and a branch closes the issue group. A younger instruction that is left behind is flagged for holding, so fetch can present it again. A stall input from downstream busy logic blocks all issue.

All results are registered, so the decision for the inputs sampled at one rising edge shows on the outputs right after that edge.

Top module: `pair_dispatch`

## Requirements
- R1: While reset is high, and in the cycle after it, the issue count is 0 and the two pipe selects and the hold flag are 0.
- R2: When the stall input is high, the issue count is 0, both pipe selects are 0, and the hold flag equals the younger valid flag.
- R3: When the older instruction is valid and there is no stall, it always issues, so the count is 1 or 2.
- R4: Both issue (count 2) exactly when both are valid, there is no stall, the older class is arith (0), load (1) or store (2), and the younger class is arith (0), integer multiply (3), integer divide (4), branch (5), FP add (6), FP multiply (7) or FP divide/sqrt (8).
- R5: An older instruction of class 3 to 8 issues alone on the second pipe. This includes a branch (5), which closes the group.
- R6: A younger instruction of class load (1) or store (2) never pairs, because the memory pipe's only adder is taken by the older instruction.
- R7: Class codes 9 to 15 mean unknown or multi-operation. Such an instruction takes both slots, so it never pairs in either position.
- R8: The pipe select is 0 for the memory pipe and 1 for the second pipe. An issued older instruction of class 0, 1 or 2 gets 0, and any other issued older instruction gets 1. An issued younger instruction gets 1. An instruction that does not issue has select 0.
- R9: When two instructions issue, they are on different pipes, so no unit of the second pipe is claimed twice.
- R10: The hold flag is 1 exactly when the younger instruction is valid and did not issue.
- R11: If the older instruction is not valid, nothing issues, even when the younger one is valid.
- R12: Every result is due on the outputs one clock after the inputs it depends on are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Downstream busy; blocks all issue |
| old_vld_i | input | 1 | Older instruction present |
| old_cls_i | input | 4 | Older instruction class code |
| yng_vld_i | input | 1 | Younger instruction present |
| yng_cls_i | input | 4 | Younger instruction class code |
| issue_cnt_o | output | 2 | Number issued this cycle (0, 1 or 2) |
| old_pipe_o | output | 1 | Pipe of the older instruction (0 memory, 1 second) |
| yng_pipe_o | output | 1 | Pipe of the younger instruction |
| yng_hold_o | output | 1 | Younger instruction must be presented again |

## Verification
Every output is one register stage from the inputs, so each result is due exactly one rising edge after the stimulus that causes it (R12). The bench changes inputs on the falling edge. It compares the count, both pipe selects and the hold flag at the next falling edge against a behavioural model fed with those same inputs. A new stimulus goes on in that same half-cycle, so every comparison pairs one stimulus with one decision. The sweep covers all 256 class pairs under four valid/stall patterns, and also checks the outputs during reset.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W = 4;
  localparam int CNT_W = 2;
  localparam int SLOTS = 2;

  localparam logic [CLS_W-1:0] C_ALU  = 4'd0;
  localparam logic [CLS_W-1:0] C_LD   = 4'd1;
  localparam logic [CLS_W-1:0] C_ST   = 4'd2;
  localparam logic [CLS_W-1:0] C_IMUL = 4'd3;
  localparam logic [CLS_W-1:0] C_IDIV = 4'd4;
  localparam logic [CLS_W-1:0] C_BR   = 4'd5;
  localparam logic [CLS_W-1:0] C_FADD = 4'd6;
  localparam logic [CLS_W-1:0] C_FMUL = 4'd7;
  localparam logic [CLS_W-1:0] C_FDIV = 4'd8;
  localparam logic [CLS_W-1:0] C_LAST_KNOWN = 4'd8;

  typedef struct packed {
    logic first_ok;
    logic second_ok;
    logic mem_pipe;
    logic solo;
  } cls_attr_t;
endpackage

// File: rtl/pair_cls_decode.sv
module pair_cls_decode
  import pair_pkg::*;
#(
  parameter int CLS_W = pair_pkg::CLS_W
) (
  input  logic [CLS_W-1:0] cls_i,
  output cls_attr_t        attr_o
);
  always_comb begin
    attr_o = '0;
    if (cls_i > CLS_W'(C_LAST_KNOWN)) begin
      attr_o.solo = 1'b1;
    end else begin
      attr_o.mem_pipe  = (cls_i == CLS_W'(C_ALU)) || (cls_i == CLS_W'(C_LD)) ||
                         (cls_i == CLS_W'(C_ST));
      attr_o.first_ok  = attr_o.mem_pipe;
      attr_o.second_ok = (cls_i != CLS_W'(C_LD)) && (cls_i != CLS_W'(C_ST));
    end
  end
endmodule

// File: rtl/pair_decide.sv
module pair_decide
  import pair_pkg::*;
#(
  parameter int CNT_W = pair_pkg::CNT_W
) (
  input  logic             stall_i,
  input  logic             old_vld_i,
  input  logic             yng_vld_i,
  input  cls_attr_t        old_attr_i,
  input  cls_attr_t        yng_attr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             old_pipe_o,
  output logic             yng_pipe_o,
  output logic             hold_o
);
  logic go_old;
  logic go_pair;

  always_comb begin
    go_old  = old_vld_i && !stall_i;
    go_pair = go_old && yng_vld_i &&
              old_attr_i.first_ok && !old_attr_i.solo &&
              yng_attr_i.second_ok && !yng_attr_i.solo;
    if (go_pair)     cnt_o = CNT_W'(2);
    else if (go_old) cnt_o = CNT_W'(1);
    else             cnt_o = '0;
    old_pipe_o = go_old && !old_attr_i.mem_pipe;
    yng_pipe_o = go_pair;
    hold_o     = yng_vld_i && !go_pair;
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_pkg::*;
#(
  parameter int CLS_W = pair_pkg::CLS_W,
  parameter int CNT_W = pair_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_i,
  input  logic             old_vld_i,
  input  logic [CLS_W-1:0] old_cls_i,
  input  logic             yng_vld_i,
  input  logic [CLS_W-1:0] yng_cls_i,
  output logic [CNT_W-1:0] issue_cnt_o,
  output logic             old_pipe_o,
  output logic             yng_pipe_o,
  output logic             yng_hold_o
);
  localparam int NSLOT = pair_pkg::SLOTS;

  logic [CLS_W-1:0] slot_cls [NSLOT];
  cls_attr_t        slot_attr[NSLOT];

  assign slot_cls[0] = old_cls_i;
  assign slot_cls[1] = yng_cls_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    pair_cls_decode #(.CLS_W(CLS_W)) u_dec (
      .cls_i  (slot_cls[g]),
      .attr_o (slot_attr[g])
    );
  end

  logic [CNT_W-1:0] cnt_n;
  logic             old_pipe_n;
  logic             yng_pipe_n;
  logic             hold_n;

  pair_decide #(.CNT_W(CNT_W)) u_decide (
    .stall_i    (stall_i),
    .old_vld_i  (old_vld_i),
    .yng_vld_i  (yng_vld_i),
    .old_attr_i (slot_attr[0]),
    .yng_attr_i (slot_attr[1]),
    .cnt_o      (cnt_n),
    .old_pipe_o (old_pipe_n),
    .yng_pipe_o (yng_pipe_n),
    .hold_o     (hold_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_cnt_o <= '0;
      old_pipe_o  <= 1'b0;
      yng_pipe_o  <= 1'b0;
      yng_hold_o  <= 1'b0;
    end else begin
      issue_cnt_o <= cnt_n;
      old_pipe_o  <= old_pipe_n;
      yng_pipe_o  <= yng_pipe_n;
      yng_hold_o  <= hold_n;
    end
  end
endmodule

// File: rtl/pair_dispatch_chk.sv
module pair_dispatch_chk #(
  parameter int CLS_W = pair_pkg::CLS_W,
  parameter int CNT_W = pair_pkg::CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_i,
  input logic             old_vld_i,
  input logic [CLS_W-1:0] old_cls_i,
  input logic             yng_vld_i,
  input logic [CLS_W-1:0] yng_cls_i,
  input logic [CNT_W-1:0] issue_cnt_o,
  input logic             old_pipe_o,
  input logic             yng_pipe_o,
  input logic             yng_hold_o
);
  localparam logic [CLS_W-1:0] SOLO_MIN = CLS_W'(9);

  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stall_i)) |-> (issue_cnt_o == '0 && yng_hold_o == $past(yng_vld_i)));

  a_r3_old_goes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(old_vld_i && !stall_i)) |-> (issue_cnt_o != '0));

  a_r7_solo_alone: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(old_cls_i >= SOLO_MIN || yng_cls_i >= SOLO_MIN)) |-> (issue_cnt_o != CNT_W'(2)));

  a_r8_young_second: assert property (@(posedge clk) disable iff (rst)
    (issue_cnt_o == CNT_W'(2)) |-> yng_pipe_o);

  a_r9_split_pipes: assert property (@(posedge clk) disable iff (rst)
    (issue_cnt_o == CNT_W'(2)) |-> (old_pipe_o != yng_pipe_o));

  a_r10_hold_iff_left: assert property (@(posedge clk) disable iff (rst)
    (issue_cnt_o == CNT_W'(2)) |-> !yng_hold_o);

  a_r11_no_old_no_issue: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!old_vld_i)) |-> (issue_cnt_o == '0 && !old_pipe_o && !yng_pipe_o));

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (issue_cnt_o == '0 && !yng_hold_o));
endmodule

bind pair_dispatch pair_dispatch_chk #(.CLS_W(CLS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pair_dispatch_tb.sv
module pair_dispatch_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall_i = 1'b0;
  logic       old_vld_i = 1'b0;
  logic [3:0] old_cls_i = '0;
  logic       yng_vld_i = 1'b0;
  logic [3:0] yng_cls_i = '0;
  logic [1:0] issue_cnt_o;
  logic       old_pipe_o;
  logic       yng_pipe_o;
  logic       yng_hold_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  pair_dispatch u_dut (
    .clk(clk), .rst(rst), .stall_i(stall_i),
    .old_vld_i(old_vld_i), .old_cls_i(old_cls_i),
    .yng_vld_i(yng_vld_i), .yng_cls_i(yng_cls_i),
    .issue_cnt_o(issue_cnt_o), .old_pipe_o(old_pipe_o),
    .yng_pipe_o(yng_pipe_o), .yng_hold_o(yng_hold_o)
  );

  function automatic bit in_list(input int c, input int lst[$]);
    foreach (lst[i]) if (lst[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model(input bit st, input bit v0, input int c0, input bit v1, input int c1,
                       output int cnt, output bit p0, output bit p1, output bit h,
                       output string tag);
    int first_set[$]  = '{0, 1, 2};
    int second_set[$] = '{0, 3, 4, 5, 6, 7, 8};
    bit pair;
    pair = 1'b0;
    if (st)                          tag = "R2";
    else if (!v0)                    tag = "R11";
    else if (!v1)                    tag = "R3";
    else if (c0 >= 9 || c1 >= 9)     tag = "R7";
    else if (!in_list(c0, first_set)) tag = "R5";
    else if (!in_list(c1, second_set)) tag = "R6";
    else begin tag = "R4"; pair = 1'b1; end
    cnt = (st || !v0) ? 0 : (pair ? 2 : 1);
    p0  = (cnt > 0) && !in_list(c0, first_set);
    p1  = pair;
    h   = v1 && !pair;
  endtask

  // R12: inputs placed at a falling edge are judged at the next falling edge.
  task automatic apply(input bit st, input bit v0, input int c0, input bit v1, input int c1);
    int cnt; bit p0, p1, h; string tag;
    stall_i = st; old_vld_i = v0; old_cls_i = 4'(c0); yng_vld_i = v1; yng_cls_i = 4'(c1);
    model(st, v0, c0, v1, c1, cnt, p0, p1, h, tag);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (int'(issue_cnt_o) != cnt) begin
      n_bad++;
      $display("FAIL %s R12 count cls %0d/%0d: got %0d exp %0d", tag, c0, c1, issue_cnt_o, cnt);
    end
    if (old_pipe_o != p0 || yng_pipe_o != p1) begin
      n_bad++;
      $display("FAIL R8 pipes cls %0d/%0d: got %0b%0b exp %0b%0b", c0, c1, old_pipe_o, yng_pipe_o, p0, p1);
    end
    if (yng_hold_o != h) begin
      n_bad++;
      $display("FAIL R10 hold cls %0d/%0d: got %0b exp %0b", c0, c1, yng_hold_o, h);
    end
    if (issue_cnt_o == 2'd2 && old_pipe_o == yng_pipe_o) begin
      n_bad++;
      $display("FAIL R9 shared pipe: got %0b%0b exp differing", old_pipe_o, yng_pipe_o);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    stall_i = 1'b0; old_vld_i = 1'b1; old_cls_i = 4'd0; yng_vld_i = 1'b1; yng_cls_i = 4'd3;
    repeat (3) @(negedge clk);
    n_vec++;
    if (issue_cnt_o != 2'd0 || old_pipe_o || yng_pipe_o || yng_hold_o) begin
      n_bad++;
      $display("FAIL R1 reset: got %0d%0b%0b%0b exp 0000", issue_cnt_o, old_pipe_o, yng_pipe_o, yng_hold_o);
    end
    rst = 1'b0;
    // directed cases
    apply(0, 1, 1, 1, 5);   // R4 load + branch pair
    apply(0, 1, 5, 1, 0);   // R5 branch older closes group
    apply(0, 1, 0, 1, 0);   // R8 arith+arith split across pipes
    apply(0, 1, 2, 1, 1);   // R6 store + load
    apply(0, 1, 15, 1, 0);  // R7 multi older
    apply(0, 1, 0, 1, 9);   // R7 unknown younger
    apply(1, 1, 0, 1, 3);   // R2 stall
    apply(0, 0, 0, 1, 0);   // R11 no older
    apply(0, 1, 7, 0, 0);   // R3 FP multiply alone
    // full sweep
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          case (k)
            0: apply(0, 1, i, 1, j);
            1: apply(0, 1, i, 0, j);
            2: apply(1, 1, i, 1, j);
            default: apply(0, 0, i, 1, j);
          endcase
    done = 1'b1;
    summary();
    $finish;
  end
endmodule